// File: doc/BRIEF.md
# Programmable PIO Cycle Timing Generator

This block sequences programmed-I/O register and data cycles toward an attached disk drive. A requester presents a cycle with a class flag, a direction bit, a register address and chip selects. The block holds two programmable timing bytes, one for data-port cycles and one for command/control-port cycles. Both drives on the channel share these bytes. When a request is accepted, the block picks the byte for its class and expands it into setup, strobe-active and hold clock counts.

The cycle then runs in three phases. In the setup phase, address and chip select are valid with no strobe. In the active phase, the read or write strobe is asserted. In the hold phase, the strobe is released while address and chip select remain valid. A one-clock done pulse follows. When the drive-ready wait is enabled, the active phase is stretched for as long as the ready input stays low. Data latching is left to the surrounding logic.

Top module: `pio_timing_gen`

## Requirements
- R1: Timing byte bits [7:6] give the setup phase length: codes 0,1,2,3 give 1,2,3,4 clocks.
- R2: Timing byte bits [2:0] give the strobe-active length: codes 0..7 give 2,3,4,5,6,8,12,16 clocks.
- R3: Timing byte bits [5:3] give the hold length: codes 0..7 give 1,2,3,4,5,6,8,12 clocks.
- R4: Each accepted cycle runs setup, then active, then hold. It is followed by exactly one clock of done_o, with cs_o and addr_o cleared in that clock.
- R5: A cycle with cls_i=0 uses the data timing byte, and a cycle with cls_i=1 uses the command timing byte.
- R6: After reset the data timing byte is 0xF5 (4/8/8 clocks) and the command timing byte is 0xDE (4/12/4 clocks). All outputs are low during reset.
- R7: With iordy_en_i=1, the active phase does not end while iordy_i is low, even after its programmed count has expired.
- R8: With iordy_en_i=0, iordy_i has no effect on the active length.
- R9: A request that arrives while a cycle is in progress is ignored: it starts no cycle and does not change the running cycle's address.
- R10: A timing byte write takes effect from the next accepted cycle and never alters a cycle already in progress.
- R11: During the active phase rd_o is high for reads (wr_i=0) and wr_o is high for writes (wr_i=1). The two are never high together.
- R12: addr_o and cs_o hold the values captured at acceptance through setup, active and hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tmg_we_i | input | 1 | Timing byte write strobe |
| tmg_sel_i | input | 1 | Timing byte select: 0 data, 1 command |
| tmg_wdata_i | input | 8 | Timing byte value |
| iordy_en_i | input | 1 | Enable the drive-ready wait |
| req_i | input | 1 | Cycle request, sampled in idle |
| cls_i | input | 1 | Cycle class: 0 data port, 1 command/control port |
| wr_i | input | 1 | Direction: 1 write, 0 read |
| req_addr_i | input | 3 | Register address for the cycle |
| req_cs_i | input | 2 | Chip selects for the cycle |
| iordy_i | input | 1 | Drive ready, low requests wait |
| addr_o | output | 3 | Drive register address |
| cs_o | output | 2 | Drive chip selects, active high |
| rd_o | output | 1 | Read strobe, active high |
| wr_o | output | 1 | Write strobe, active high |
| done_o | output | 1 | One-clock cycle completion pulse |

## Verification
A wrong phase counter or a mis-decoded timing code shows up as a strobe that is too long or too short. It can also show up as a setup or hold window with the wrong length, visible at rd_o/wr_o and cs_o within the same cycle. A stuck state appears as a missing done_o pulse or as chip selects that stay high after completion. A wrong class or direction latch shows up in the first strobe clock. The iordy wait shows itself only through the strobe length, so both the stretched case and the ignored case are measured.

// File: rtl/pio_tmg_pkg.sv
package pio_tmg_pkg;
  localparam int CNT_W = 5;
  localparam int NCLS  = 2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_ACTIVE, ST_HOLD, ST_DONE
  } phase_e;

  typedef struct packed {
    logic [CNT_W-1:0] setup;
    logic [CNT_W-1:0] active;
    logic [CNT_W-1:0] hold;
  } tmg_cnt_t;

  function automatic logic [CNT_W-1:0] setup_clks(input logic [1:0] code);
    return CNT_W'(code) + CNT_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] hold_clks(input logic [2:0] code);
    case (code)
      3'd6:    return CNT_W'(8);
      3'd7:    return CNT_W'(12);
      default: return CNT_W'(code) + CNT_W'(1);
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] active_clks(input logic [2:0] code);
    case (code)
      3'd5:    return CNT_W'(8);
      3'd6:    return CNT_W'(12);
      3'd7:    return CNT_W'(16);
      default: return CNT_W'(code) + CNT_W'(2);
    endcase
  endfunction
endpackage

// File: rtl/pio_tmg_regs.sv
module pio_tmg_regs
  import pio_tmg_pkg::*;
#(
  parameter logic [7:0] RST_DATA = 8'hF5,
  parameter logic [7:0] RST_CMD  = 8'hDE
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic                  sel_i,
  input  logic [7:0]            wdata_i,
  output logic [NCLS-1:0][7:0]  tmg_o
);
  localparam logic [NCLS-1:0][7:0] RST_VAL = {RST_CMD, RST_DATA};

  for (genvar g = 0; g < NCLS; g++) begin : g_reg
    logic [7:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                       q <= RST_VAL[g];
      else if (we_i && (int'(sel_i) == g)) q <= wdata_i;
    end
    assign tmg_o[g] = q;

    p_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && (int'(sel_i) == g)) |=> (q == $past(wdata_i)));
  end
endmodule

// File: rtl/pio_tmg_decode.sv
module pio_tmg_decode
  import pio_tmg_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic [7:0] tmg_i,
  output tmg_cnt_t cnt_o
);
  always_comb begin
    cnt_o.setup  = setup_clks(tmg_i[7:6]);
    cnt_o.hold   = hold_clks(tmg_i[5:3]);
    cnt_o.active = active_clks(tmg_i[2:0]);
  end

  p_active_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o.active >= CNT_W'(2)) && (cnt_o.active <= CNT_W'(16)));
  p_hold_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o.hold >= CNT_W'(1)) && (cnt_o.hold <= CNT_W'(12)));
endmodule

// File: rtl/pio_tmg_fsm.sv
module pio_tmg_fsm
  import pio_tmg_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int CS_W   = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  tmg_cnt_t [NCLS-1:0]  cnt_tab_i,
  input  logic                 iordy_en_i,
  input  logic                 req_i,
  input  logic                 cls_i,
  input  logic                 wr_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [CS_W-1:0]      cs_i,
  input  logic                 iordy_i,
  output logic [ADDR_W-1:0]    addr_o,
  output logic [CS_W-1:0]      cs_o,
  output logic                 rd_o,
  output logic                 wr_o,
  output logic                 done_o
);
  phase_e            state_q;
  tmg_cnt_t          cur_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CS_W-1:0]   cs_q;
  logic              wr_q;
  logic              ien_q;
  logic              in_cyc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      cnt_q   <= '0;
      addr_q  <= '0;
      cs_q    <= '0;
      wr_q    <= 1'b0;
      ien_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (req_i) begin
          cur_q   <= cnt_tab_i[cls_i];
          cnt_q   <= cnt_tab_i[cls_i].setup - CNT_W'(1);
          addr_q  <= addr_i;
          cs_q    <= cs_i;
          wr_q    <= wr_i;
          ien_q   <= iordy_en_i;
          state_q <= ST_SETUP;
        end
        ST_SETUP: begin
          if (cnt_q == '0) begin
            cnt_q   <= cur_q.active - CNT_W'(1);
            state_q <= ST_ACTIVE;
          end else cnt_q <= cnt_q - CNT_W'(1);
        end
        ST_ACTIVE: begin
          if (cnt_q != '0) cnt_q <= cnt_q - CNT_W'(1);
          else if (!ien_q || iordy_i) begin
            cnt_q   <= cur_q.hold - CNT_W'(1);
            state_q <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (cnt_q == '0) state_q <= ST_DONE;
          else             cnt_q   <= cnt_q - CNT_W'(1);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign in_cyc = (state_q == ST_SETUP) || (state_q == ST_ACTIVE) || (state_q == ST_HOLD);
  assign addr_o = in_cyc ? addr_q : '0;
  assign cs_o   = in_cyc ? cs_q : '0;
  assign rd_o   = (state_q == ST_ACTIVE) && !wr_q;
  assign wr_o   = (state_q == ST_ACTIVE) && wr_q;
  assign done_o = (state_q == ST_DONE);

  p_strobe_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_o && wr_o));
  p_done_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_setup_first_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_o || wr_o) |-> $past(state_q == ST_SETUP));
  p_iordy_wait_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACTIVE && ien_q && !iordy_i) |=> (state_q == ST_ACTIVE));
  p_iordy_ignored_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACTIVE && !ien_q && cnt_q == '0) |=> (state_q == ST_HOLD));
  p_addr_stable_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SETUP || state_q == ST_ACTIVE) |=> $stable(addr_o));
  p_busy_ignore_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && req_i) |=> $stable(cur_q));
endmodule

// File: rtl/pio_timing_gen.sv
module pio_timing_gen
  import pio_tmg_pkg::*;
#(
  parameter int         ADDR_W   = 3,
  parameter int         CS_W     = 2,
  parameter logic [7:0] RST_DATA = 8'hF5,
  parameter logic [7:0] RST_CMD  = 8'hDE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tmg_we_i,
  input  logic              tmg_sel_i,
  input  logic [7:0]        tmg_wdata_i,
  input  logic              iordy_en_i,
  input  logic              req_i,
  input  logic              cls_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [CS_W-1:0]   req_cs_i,
  input  logic              iordy_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CS_W-1:0]   cs_o,
  output logic              rd_o,
  output logic              wr_o,
  output logic              done_o
);
  logic [NCLS-1:0][7:0] tmg;
  tmg_cnt_t [NCLS-1:0]  cnt_tab;

  pio_tmg_regs #(.RST_DATA(RST_DATA), .RST_CMD(RST_CMD)) u_regs (
    .clk_i, .rst_ni, .we_i(tmg_we_i), .sel_i(tmg_sel_i),
    .wdata_i(tmg_wdata_i), .tmg_o(tmg)
  );

  for (genvar g = 0; g < NCLS; g++) begin : g_dec
    pio_tmg_decode u_dec (.clk_i, .rst_ni, .tmg_i(tmg[g]), .cnt_o(cnt_tab[g]));
  end

  pio_tmg_fsm #(.ADDR_W(ADDR_W), .CS_W(CS_W)) u_fsm (
    .clk_i, .rst_ni, .cnt_tab_i(cnt_tab), .iordy_en_i, .req_i, .cls_i, .wr_i,
    .addr_i(req_addr_i), .cs_i(req_cs_i), .iordy_i,
    .addr_o, .cs_o, .rd_o, .wr_o, .done_o
  );
endmodule

// File: tb/pio_timing_gen_tb.sv
module pio_timing_gen_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [7:0] tb;
    logic [4:0] s;
    logic [4:0] a;
    logic [4:0] h;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{8'h00, 5'd1, 5'd2,  5'd1},
    '{8'h09, 5'd1, 5'd3,  5'd2},
    '{8'h52, 5'd2, 5'd4,  5'd3},
    '{8'h9B, 5'd3, 5'd5,  5'd4},
    '{8'hE4, 5'd4, 5'd6,  5'd5},
    '{8'h2D, 5'd1, 5'd8,  5'd6},
    '{8'h76, 5'd2, 5'd12, 5'd8},
    '{8'hBF, 5'd3, 5'd16, 5'd12}
  };

  logic clk = 0, rst_ni = 0;
  logic tmg_we = 0, tmg_sel = 0, iordy_en = 0, req = 0, cls = 0, wr = 0, iordy = 1;
  logic [7:0] tmg_wdata = 0;
  logic [2:0] req_addr = 0, addr_o;
  logic [1:0] req_cs = 0, cs_o;
  logic rd_o, wr_o, done_o;
  int tests = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pio_timing_gen u_dut (
    .clk_i(clk), .rst_ni, .tmg_we_i(tmg_we), .tmg_sel_i(tmg_sel), .tmg_wdata_i(tmg_wdata),
    .iordy_en_i(iordy_en), .req_i(req), .cls_i(cls), .wr_i(wr), .req_addr_i(req_addr),
    .req_cs_i(req_cs), .iordy_i(iordy), .addr_o, .cs_o, .rd_o, .wr_o, .done_o
  );

  task automatic chk(input string tag, input int got, input int exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic write_tmg(input logic sel, input logic [7:0] v);
    @(negedge clk); tmg_we = 1; tmg_sel = sel; tmg_wdata = v;
    @(negedge clk); tmg_we = 0;
  endtask

  // measures one cycle; iordy_rel: 0 = ready high, else raise after that many strobe clocks
  task automatic run_cyc(input logic c_cls, input logic c_wr, input logic [2:0] a,
                         input logic [1:0] c, input int iordy_rel, input logic intrude,
                         input logic mid_we, input logic [7:0] mid_byte,
                         output int s, output int act, output int h);
    int bad = 0, dir_bad = 0, addr_bad = 0;
    bit got_done = 0;
    s = 0; act = 0; h = 0;
    @(negedge clk);
    req = 1; cls = c_cls; wr = c_wr; req_addr = a; req_cs = c;
    iordy = (iordy_rel == 0);
    @(negedge clk);
    req = 0; req_addr = ~a;
    for (int k = 0; k < 200 && !got_done; k++) begin
      if (done_o) got_done = 1;
      else begin
        if (rd_o || wr_o) begin
          act++;
          if (rd_o == c_wr || wr_o != c_wr) dir_bad++;
          if (iordy_rel != 0 && act == iordy_rel) iordy = 1;
          if (act == 1 && intrude) begin req = 1; req_addr = a ^ 3'b111; end
          if (act == 1 && mid_we) begin tmg_we = 1; tmg_sel = 0; tmg_wdata = mid_byte; end
        end else if (cs_o == c && act == 0) s++;
        else if (cs_o == c) h++;
        else bad++;
        if (addr_o != a) addr_bad++;
        @(negedge clk);
        req = 0; tmg_we = 0;
      end
    end
    chk("R4 done seen", int'(got_done), 1);
    chk("R12 cs valid in every phase", bad, 0);
    chk("R12 addr held", addr_bad, 0);
    chk("R11 strobe direction", dir_bad, 0);
    chk("R4 cs cleared with done", int'(cs_o), 0);
    @(negedge clk);
    chk("R4 done one clock", int'(done_o), 0);
    chk("R9 no extra cycle", int'(cs_o) + int'(rd_o) + int'(wr_o), 0);
    iordy = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    tests++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int s, a, h;
    #(CLK_PERIOD * 3 + 1);
    chk("R6 reset outputs", int'(cs_o) + int'(rd_o) + int'(wr_o) + int'(done_o) + int'(addr_o), 0);
    rst_ni = 1;
    // R6 reset timing bytes
    run_cyc(0, 0, 3'd5, 2'b01, 0, 0, 0, 8'h0, s, a, h);
    chk("R6 data setup", s, 4); chk("R6 data active", a, 8); chk("R6 data hold", h, 8);
    run_cyc(1, 1, 3'd6, 2'b10, 0, 0, 0, 8'h0, s, a, h);
    chk("R6 cmd setup", s, 4); chk("R6 cmd active", a, 12); chk("R6 cmd hold", h, 4);

    for (int i = 0; i < 8; i++) begin
      int j;
      j = (i + 3) % 8;
      write_tmg(0, VEC[i].tb);
      write_tmg(1, VEC[j].tb);
      run_cyc(0, 0, 3'(i), 2'b01, 0, 0, 0, 8'h0, s, a, h);
      chk("R1 setup", s, int'(VEC[i].s));
      chk("R2 active", a, int'(VEC[i].a));
      chk("R3 hold", h, int'(VEC[i].h));
      run_cyc(1, 1, 3'(j), 2'b10, 0, 0, 0, 8'h0, s, a, h);
      chk("R5 cmd class setup", s, int'(VEC[j].s));
      chk("R5 cmd class active", a, int'(VEC[j].a));
      chk("R5 cmd class hold", h, int'(VEC[j].h));
    end

    write_tmg(0, 8'h00);
    iordy_en = 1;
    run_cyc(0, 0, 3'd1, 2'b01, 7, 0, 0, 8'h0, s, a, h);
    chk("R7 stretched active", a, 7);
    run_cyc(0, 1, 3'd1, 2'b01, 1, 0, 0, 8'h0, s, a, h);
    chk("R7 ready early no stretch", a, 2);
    iordy_en = 0;
    run_cyc(0, 0, 3'd2, 2'b01, 999, 0, 0, 8'h0, s, a, h);
    chk("R8 iordy ignored", a, 2);

    run_cyc(0, 0, 3'd3, 2'b11, 0, 1, 0, 8'h0, s, a, h);
    chk("R9 active unchanged", a, 2);

    run_cyc(0, 0, 3'd4, 2'b01, 0, 0, 1, 8'hBF, s, a, h);
    chk("R10 old setup", s, 1); chk("R10 old active", a, 2); chk("R10 old hold", h, 1);
    run_cyc(0, 1, 3'd4, 2'b01, 0, 0, 0, 8'h0, s, a, h);
    chk("R10 new setup", s, 3); chk("R10 new active", a, 16); chk("R10 new hold", h, 12);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule